// File: doc/BRIEF.md
# Debug Data Scan Chain

This block is a 67-bit test data register. It sits between a processor core and a test access port. When the chain is selected, it can do three things. A capture strobe loads a snapshot of the core's instruction word, its data bus and three control bits. A shift strobe moves the chain one place per cycle, from the serial input toward the serial output. An update strobe copies the shifted contents into a parallel register. That register feeds a scanned instruction to the core, sets a speed-sync request and, in external-test mode, drives the data bus.

The chain runs from bit 1 at the output end to bit 67 at the input end.

- Bits 32 to 1 hold the instruction word, with bit 1 as instruction bit 0.
- Bit 33 is the speed-sync bit.
- Bit 34 is the watchpoint-with-breakpoint flag.
- Bit 35 is the data-bus drive enable.
- Bits 36 to 67 hold the data bus in reversed order: bit 36 is data bit 31 and bit 67 is data bit 0.

The speed-sync bit has a second use. On the first capture after the core enters debug state, it reports why the core stopped: 0 for a breakpoint and 1 for a watchpoint. Every later capture reads the core's live speed-sync value.

Top module: `dbg_scan_chain`

## Requirements
- R1: After reset, tdo_o, instr_o, syssync_o, data_o and data_oe_o are all 0.
- R2: A selected capture loads the chain layout above. Bit 33 gets the speed-sync value, bit 34 gets wpt_bkpt_i, and bit 35 gets the drive enable.
- R3: While shift_i is high and the chain is selected, each cycle moves tdi_i into bit 67 and every bit one place toward bit 1. tdo_o always shows bit 1.
- R4: A selected update copies the instruction field to instr_o, bit 33 to syssync_o, and the data field, un-reversed, to data_o.
- R5: After a debug-entry pulse, the next capture loads bit 33 with the entry cause (1 = watchpoint, 0 = breakpoint). That capture clears the report.
- R6: Any capture with no pending report loads bit 33 from the live core_sync_i.
- R7: In INTEST mode, a capture loads bit 35 from core_dden_i.
- R8: In EXTEST mode, data_oe_o equals the last updated bit 35. Outside EXTEST, data_oe_o is 0.
- R9: In EXTEST mode, a capture loads the data field and bit 35 from the held update values when the held drive enable is 1. When it is 0, the data field comes from core_data_i.
- R10: While sel_i is low, the capture, shift and update strobes have no effect. The chain contents and all parallel outputs are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | This chain is the selected data register |
| intest_i | input | 1 | Internal-test mode |
| extest_i | input | 1 | External-test mode |
| capture_i | input | 1 | Capture strobe |
| shift_i | input | 1 | Shift strobe |
| update_i | input | 1 | Update strobe |
| tdi_i | input | 1 | Serial input |
| tdo_o | output | 1 | Serial output (chain bit 1) |
| core_instr_i | input | 32 | Core instruction bus |
| core_data_i | input | 32 | Data bus input value |
| core_dden_i | input | 1 | Core data-bus drive enable |
| core_sync_i | input | 1 | Live speed-sync value |
| wpt_bkpt_i | input | 1 | Breakpointed-in-execute flag |
| dbg_entry_i | input | 1 | Debug-state entry pulse |
| dbg_by_wpt_i | input | 1 | Entry cause, 1 = watchpoint |
| instr_o | output | 32 | Scanned instruction to core |
| syssync_o | output | 1 | Scanned speed-sync request |
| data_o | output | 32 | Value driven onto the data bus |
| data_oe_o | output | 1 | Data-bus drive enable |

## Verification
The bench captures twice after each debug entry, once after a watchpoint and once after a breakpoint. The live speed-sync value is set opposite to the cause each time. A design whose report never clears, or never appears, gives the wrong bit 33 on one of those captures. Distinct, asymmetric data patterns expose a data field placed without its bit reversal, both in the captured chain and on data_o. The EXTEST sequence captures with the held drive enable at 1 and at 0 while the live bus carries a different value, which catches a design that takes the wrong data source. A scan-in done while the chain is deselected must leave both the shifted contents and the outputs unchanged.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int unsigned DEF_INSTR_W = 32;
  localparam int unsigned DEF_DATA_W  = 32;
  localparam int unsigned CTRL_W      = 3;

  typedef enum logic [1:0] {
    OP_HOLD    = 2'd0,
    OP_CAPTURE = 2'd1,
    OP_SHIFT   = 2'd2
  } sr_op_e;
endpackage

// File: rtl/dsc_shift_reg.sv
module dsc_shift_reg
  import dsc_pkg::*;
#(
  parameter int unsigned LEN = 67
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  sr_op_e         op_i,
  input  logic [LEN-1:0] par_i,
  input  logic           tdi_i,
  output logic [LEN-1:0] q_o
);
  logic [LEN-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else begin
      unique case (op_i)
        OP_CAPTURE: q_q <= par_i;
        OP_SHIFT:   q_q <= {tdi_i, q_q[LEN-1:1]};
        default:    q_q <= q_q;
      endcase
    end
  end

  assign q_o = q_q;

  // R3
  shift_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SHIFT) |=> (q_q[LEN-1] == $past(tdi_i)) && (q_q[0] == $past(q_q[1])));
  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_HOLD) |=> $stable(q_q));
endmodule

// File: rtl/dsc_cause_track.sv
module dsc_cause_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic entry_i,
  input  logic by_wpt_i,
  input  logic cap_i,
  input  logic live_i,
  output logic sync_o
);
  logic pending_q, cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      cause_q   <= 1'b0;
    end else if (entry_i) begin
      pending_q <= 1'b1;
      cause_q   <= by_wpt_i;
    end else if (cap_i) begin
      pending_q <= 1'b0;
    end
  end

  // one-shot cause report, then the live value
  assign sync_o = pending_q ? cause_q : live_i;

  // R5
  entry_arms_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_i |=> (sync_o == $past(by_wpt_i)) || !$stable(live_i) || (sync_o == live_i));
  // R5
  report_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !entry_i) |=> (sync_o == live_i));
endmodule

// File: rtl/dsc_update_reg.sv
module dsc_update_reg #(
  parameter int unsigned INSTR_W = 32,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               sync_i,
  input  logic               dden_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [INSTR_W-1:0] instr_o,
  output logic               sync_o,
  output logic               dden_o,
  output logic [DATA_W-1:0]  data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      instr_o <= '0;
      sync_o  <= 1'b0;
      dden_o  <= 1'b0;
      data_o  <= '0;
    end else if (en_i) begin
      instr_o <= instr_i;
      sync_o  <= sync_i;
      dden_o  <= dden_i;
      data_o  <= data_i;
    end
  end

  // R10
  upd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(instr_o) && $stable(data_o) && $stable(dden_o) && $stable(sync_o));
endmodule

// File: rtl/dbg_scan_chain.sv
module dbg_scan_chain
  import dsc_pkg::*;
#(
  parameter int unsigned INSTR_W = DEF_INSTR_W,
  parameter int unsigned DATA_W  = DEF_DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sel_i,
  input  logic               intest_i,
  input  logic               extest_i,
  input  logic               capture_i,
  input  logic               shift_i,
  input  logic               update_i,
  input  logic               tdi_i,
  output logic               tdo_o,
  input  logic [INSTR_W-1:0] core_instr_i,
  input  logic [DATA_W-1:0]  core_data_i,
  input  logic               core_dden_i,
  input  logic               core_sync_i,
  input  logic               wpt_bkpt_i,
  input  logic               dbg_entry_i,
  input  logic               dbg_by_wpt_i,
  output logic [INSTR_W-1:0] instr_o,
  output logic               syssync_o,
  output logic [DATA_W-1:0]  data_o,
  output logic               data_oe_o
);
  localparam int unsigned LEN      = INSTR_W + CTRL_W + DATA_W;
  localparam int unsigned POS_SYNC = INSTR_W;
  localparam int unsigned POS_WPT  = INSTR_W + 1;
  localparam int unsigned POS_DDEN = INSTR_W + 2;
  localparam int unsigned POS_DATA = INSTR_W + CTRL_W;

  sr_op_e            op;
  logic [LEN-1:0]    par, sr;
  logic              cap_sel, upd_sel, cap_sync;
  logic              upd_dden;
  logic [DATA_W-1:0] upd_data, cap_data, sr_data;
  logic              cap_dden;

  assign cap_sel = sel_i && capture_i;
  assign upd_sel = sel_i && update_i && !capture_i && !shift_i;

  always_comb begin
    if (!sel_i)         op = OP_HOLD;
    else if (capture_i) op = OP_CAPTURE;
    else if (shift_i)   op = OP_SHIFT;
    else                op = OP_HOLD;
  end

  dsc_cause_track i_cause (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .entry_i  (dbg_entry_i),
    .by_wpt_i (dbg_by_wpt_i),
    .cap_i    (cap_sel),
    .live_i   (core_sync_i),
    .sync_o   (cap_sync)
  );

  // EXTEST with drive enabled: bus shows held cells
  assign cap_data = (extest_i && upd_dden) ? upd_data : core_data_i;
  assign cap_dden = extest_i ? upd_dden : core_dden_i;

  assign par[INSTR_W-1:0] = core_instr_i;
  assign par[POS_SYNC]    = cap_sync;
  assign par[POS_WPT]     = wpt_bkpt_i;
  assign par[POS_DDEN]    = cap_dden;

  // data field is bit-reversed along the chain
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign par[POS_DATA + i] = cap_data[DATA_W-1-i];
    assign sr_data[i]        = sr[LEN-1-i];
  end

  dsc_shift_reg #(.LEN(LEN)) i_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .par_i  (par),
    .tdi_i  (tdi_i),
    .q_o    (sr)
  );

  dsc_update_reg #(.INSTR_W(INSTR_W), .DATA_W(DATA_W)) i_upd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (upd_sel),
    .instr_i (sr[INSTR_W-1:0]),
    .sync_i  (sr[POS_SYNC]),
    .dden_i  (sr[POS_DDEN]),
    .data_i  (sr_data),
    .instr_o (instr_o),
    .sync_o  (syssync_o),
    .dden_o  (upd_dden),
    .data_o  (upd_data)
  );

  assign tdo_o     = sr[0];
  assign data_o    = upd_data;
  assign data_oe_o = extest_i && upd_dden;

  // R8
  oe_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> extest_i);
  // R10
  desel_tdo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> $stable(tdo_o));
  // R4
  upd_instr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_sel |=> (instr_o == $past(sr[INSTR_W-1:0])));
endmodule

// File: tb/test_dbg_scan_chain.sv
module test_dbg_scan_chain;
  localparam int L = 67;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        sel = 0, intest = 0, extest = 0, cap = 0, sh = 0, upd = 0, tdi = 0;
  logic        tdo;
  logic [31:0] c_instr = '0, c_data = '0;
  logic        c_dden = 0, c_sync = 0, wpt = 0, entry = 0, by_wpt = 0;
  logic [31:0] instr_o, data_o;
  logic        sync_o, oe_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [L-1:0] exp_q[$], obs_q[$];
  string        tag_q[$];

  always #5 clk = ~clk;

  dbg_scan_chain i_dbg_scan_chain (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .intest_i(intest), .extest_i(extest),
    .capture_i(cap), .shift_i(sh), .update_i(upd), .tdi_i(tdi), .tdo_o(tdo),
    .core_instr_i(c_instr), .core_data_i(c_data), .core_dden_i(c_dden),
    .core_sync_i(c_sync), .wpt_bkpt_i(wpt), .dbg_entry_i(entry), .dbg_by_wpt_i(by_wpt),
    .instr_o(instr_o), .syssync_o(sync_o), .data_o(data_o), .data_oe_o(oe_o)
  );

  // chain image: bit k-1 holds chain bit k; data reversed from bit 36 up
  function automatic logic [L-1:0] mk(logic [31:0] ins, logic s, logic w, logic d, logic [31:0] dat);
    logic [L-1:0] v;
    v[31:0] = ins; v[32] = s; v[33] = w; v[34] = d;
    for (int j = 0; j < 32; j++) v[35+j] = dat[31-j];
    return v;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // driver: optional capture, full shift with din, optional update
  task automatic scan(bit do_cap, logic [L-1:0] din, logic [L-1:0] exp, bit do_upd, string tag);
    logic [L-1:0] obs;
    exp_q.push_back(exp); tag_q.push_back(tag);
    if (do_cap) begin
      @(negedge clk) cap = 1;
      @(negedge clk) cap = 0;
    end else @(negedge clk);
    sh = 1;
    for (int i = 0; i < L; i++) begin
      obs[i] = tdo; tdi = din[i];
      @(negedge clk);
    end
    sh = 0;
    obs_q.push_back(obs);
    if (do_upd) begin
      upd = 1;
      @(negedge clk) upd = 0;
    end
  endtask

  // monitor: compare scanned-out images against expectations
  always @(negedge clk) begin
    if (obs_q.size() > 0 && exp_q.size() > 0) begin
      logic [L-1:0] o, e;
      string t;
      o = obs_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      checks++;
      if (o !== e) begin
        errors++;
        $display("FAIL %s act=%0h exp=%0h", t, o, e);
      end
    end
  end

  task automatic pulse_entry(logic w);
    @(negedge clk) begin entry = 1; by_wpt = w; end
    @(negedge clk) entry = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    logic [L-1:0] p;
    repeat (3) @(negedge clk);
    // R1
    chk(tdo == 0 && instr_o == 0 && sync_o == 0 && data_o == 0 && oe_o == 0, "R1 reset", {instr_o, data_o}, 0);
    rst_ni = 1;
    sel = 1; intest = 1;

    // R2 R6 R7: INTEST capture, live sync, core dden
    c_instr = 32'hA5A5_0F0F; c_data = 32'h1234_5678; c_dden = 1; c_sync = 1; wpt = 0;
    scan(1, mk(32'hCAFE_BABE, 1, 0, 0, 32'hDEAD_BEEF), mk(32'hA5A5_0F0F, 1, 0, 1, 32'h1234_5678), 1, "R2 R6 R7 intest capture");
    @(negedge clk);
    // R4
    chk(instr_o == 32'hCAFE_BABE, "R4 instr", instr_o, 32'hCAFE_BABE);
    chk(data_o == 32'hDEAD_BEEF, "R4 data", data_o, 32'hDEAD_BEEF);
    chk(sync_o == 1, "R4 sync", sync_o, 1);
    // R8
    chk(oe_o == 0, "R8 no drive in intest", oe_o, 0);

    // R5: watchpoint cause, live sync opposite
    c_sync = 0; wpt = 1; c_dden = 0; c_instr = 32'h0000_0001; c_data = 32'h8000_0000;
    pulse_entry(1);
    scan(1, '0, mk(32'h1, 1, 1, 0, 32'h8000_0000), 0, "R5 watchpoint cause");
    scan(1, '0, mk(32'h1, 0, 1, 0, 32'h8000_0000), 0, "R5 R6 cause cleared");
    // R5: breakpoint cause
    c_sync = 1; wpt = 0;
    pulse_entry(0);
    scan(1, '0, mk(32'h1, 0, 0, 0, 32'h8000_0000), 0, "R5 breakpoint cause");
    scan(1, '0, mk(32'h1, 1, 0, 0, 32'h8000_0000), 0, "R5 R6 live after report");

    // R8 R9: EXTEST, held dden still 0
    intest = 0; extest = 1; c_data = 32'h0F0F_00FF; c_dden = 1;
    scan(1, mk(32'h1111_2222, 0, 0, 1, 32'h8000_0001), mk(32'h1, 1, 0, 0, 32'h0F0F_00FF), 1, "R9 extest dden0 capture");
    @(negedge clk);
    chk(oe_o == 1, "R8 drive on", oe_o, 1);
    chk(data_o == 32'h8000_0001, "R4 R8 driven value", data_o, 32'h8000_0001);
    c_data = 32'hFFFF_0000;
    scan(1, mk(32'h3, 0, 0, 0, 32'h0000_00C3), mk(32'h1, 1, 0, 1, 32'h8000_0001), 1, "R9 extest dden1 capture");
    @(negedge clk);
    chk(oe_o == 0, "R8 drive off", oe_o, 0);
    chk(instr_o == 32'h3, "R4 instr extest", instr_o, 32'h3);

    // R10: deselected strobes ignored
    p = mk(32'h7654_3210, 1, 1, 1, 32'h0101_ABCD);
    scan(0, p, mk(32'h3, 0, 0, 0, 32'h0000_00C3), 0, "R3 R10 shift-through");
    sel = 0;
    @(negedge clk) begin cap = 1; tdi = 1; end
    @(negedge clk) begin cap = 0; sh = 1; end
    repeat (5) @(negedge clk);
    sh = 0; upd = 1;
    @(negedge clk) upd = 0;
    chk(instr_o == 32'h3, "R10 instr held", instr_o, 32'h3);
    chk(oe_o == 0 && data_o == 32'h0000_00C3, "R10 data held", data_o, 32'h0000_00C3);
    chk(tdo == p[0], "R10 tdo held", tdo, p[0]);
    sel = 1;
    scan(0, '0, p, 0, "R3 R10 contents kept");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule